// File: doc/BRIEF.md
# Instruction Group Dependency Checker

This block watches a stream of decoded instructions, one per clock, and judges whether each one is legal within its instruction group. An instruction group is a run of instructions that software has marked as free of register dependencies. The group ends after an instruction that carries a stop flag or a taken-branch flag. Each instruction names up to two source registers and one destination register, each with its own valid flag. The block keeps a record of every register written so far in the open group. It raises a violation, in the same cycle as the instruction, when that instruction reads a recorded register (read-after-write) or writes one again (write-after-write).

The block only reports. It never stalls the stream, never reorders it and never assumes that the instructions of a group issue together. Alongside the verdict it marks the first instruction of each group and presents a running group number, so that a trace or a downstream monitor can tie each violation to its group. Register 0 always reads as zero and cannot be written, so it never takes part in a hazard.

Top module: `grp_hazard_chk`

## Requirements
- R1: A valid instruction whose valid source operand names a nonzero register written by an earlier instruction of the same group drives `viol_code` = 01 (read-after-write) in the same cycle. A source that matches only the same instruction's own destination is not a hazard.
- R2: A valid instruction whose valid destination names a nonzero register already written in the same group drives `viol_code` = 10 (write-after-write). When both hazards hold together the code is 11.
- R3: An instruction with `stop_after` = 1 closes its group. The next valid instruction raises `grp_start`, and no register written in the closed group, including by the closing instruction itself, causes a hazard for it.
- R4: An instruction with `br_taken` = 1 closes its group in the same way as a stop, even when `stop_after` = 0.
- R5: A group has no length limit. A write early in a long group still flags a later read after any number of other instructions and idle cycles.
- R6: Register 0 never raises a hazard. Reading it is never flagged, and a write to it is discarded, so neither a later read nor a later write of register 0 is flagged.
- R7: `viol` is 1 exactly when `viol_code` is nonzero. Both are 0 in a cycle with `in_vld` = 0, and idle cycles leave the record of written registers unchanged.
- R8: `grp_idx` is 0 after reset. It goes up by one in the cycle after each valid closing instruction, wraps modulo 2^GIW and otherwise holds.
- R9: An active reset clears the written-register record and the group number, and drives `viol`, `viol_code` and `grp_start` to 0. The first valid instruction after reset raises `grp_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | An instruction is present this cycle |
| src_a | input | RW (7) | First source register number |
| src_a_vld | input | 1 | First source is used |
| src_b | input | RW (7) | Second source register number |
| src_b_vld | input | 1 | Second source is used |
| dst | input | RW (7) | Destination register number |
| dst_vld | input | 1 | Destination is written |
| stop_after | input | 1 | Group closes after this instruction |
| br_taken | input | 1 | Instruction is a taken branch, which also closes the group |
| viol | output | 1 | Current instruction breaks the group rules |
| viol_code | output | 2 | 00 none, 01 read-after-write, 10 write-after-write, 11 both |
| grp_start | output | 1 | Current instruction is the first of its group |
| grp_idx | output | GIW (8) | Number of the group the current instruction belongs to |

## Verification
`viol`, `viol_code` and `grp_start` are combinational in the presented instruction and the stored state, so they are due in the very cycle the instruction is driven. The bench drives each instruction just after a falling edge and samples these outputs 2 ns later, before the rising edge that records the instruction. `grp_idx` and the cleared record follow the closing instruction by one rising edge, so the bench expects the new group number and the absence of hazards from the next instruction it sends. Reset acts without a clock, and its cleared outputs are sampled within the same half-cycle in which reset is asserted.

// File: rtl/grp_hazard_pkg.sv
package grp_hazard_pkg;

  typedef enum logic [1:0] {
    VC_NONE = 2'b00,
    VC_RAW  = 2'b01,
    VC_WAW  = 2'b10,
    VC_BOTH = 2'b11
  } viol_code_e;

  function automatic viol_code_e mk_code(input logic raw, input logic waw);
    viol_code_e c;
    case ({waw, raw})
      2'b01:   c = VC_RAW;
      2'b10:   c = VC_WAW;
      2'b11:   c = VC_BOTH;
      default: c = VC_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/grp_wset.sv
module grp_wset #(
  parameter int NREG = 128,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          wr_vld,
  input  logic [RW-1:0] wr_idx,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic [RW-1:0] rd_w,
  output logic          hit_a,
  output logic          hit_b,
  output logic          hit_w
);

  logic [NREG-1:0] set_q;
  logic [NREG-1:0] set_d;

  // Register 0 has no storage: its bit is a constant zero.
  assign set_d[0] = 1'b0;

  for (genvar i = 1; i < NREG; i++) begin : g_bit
    always_comb begin
      if (clr) begin
        set_d[i] = 1'b0;
      end else begin
        set_d[i] = set_q[i] | (wr_vld && (wr_idx == RW'(i)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
    end else if (en) begin
      set_q <= set_d;
    end
  end

  assign hit_a = set_q[rd_a];
  assign hit_b = set_q[rd_b];
  assign hit_w = set_q[rd_w];

endmodule

// File: rtl/grp_seq.sv
module grp_seq #(
  parameter int GIW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           close,
  output logic           at_start,
  output logic [GIW-1:0] idx
);

  logic           start_d;
  logic [GIW-1:0] idx_d;

  always_comb begin
    start_d = close;
    idx_d   = close ? idx + GIW'(1) : idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_start <= 1'b1;
      idx      <= '0;
    end else if (en) begin
      at_start <= start_d;
      idx      <= idx_d;
    end
  end

endmodule

// File: rtl/grp_classify.sv
module grp_classify
  import grp_hazard_pkg::*;
(
  input  logic       in_vld,
  input  logic       src_a_vld,
  input  logic       src_b_vld,
  input  logic       dst_vld,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       hit_w,
  output viol_code_e code
);

  logic raw;
  logic waw;

  always_comb begin
    raw  = (src_a_vld & hit_a) | (src_b_vld & hit_b);
    waw  = dst_vld & hit_w;
    code = in_vld ? mk_code(raw, waw) : VC_NONE;
  end

endmodule

// File: rtl/grp_hazard_chk.sv
module grp_hazard_chk
  import grp_hazard_pkg::*;
#(
  parameter int NREG = 128,
  parameter int RW   = $clog2(NREG),
  parameter int GIW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [RW-1:0]  src_a,
  input  logic           src_a_vld,
  input  logic [RW-1:0]  src_b,
  input  logic           src_b_vld,
  input  logic [RW-1:0]  dst,
  input  logic           dst_vld,
  input  logic           stop_after,
  input  logic           br_taken,
  output logic           viol,
  output logic [1:0]     viol_code,
  output logic           grp_start,
  output logic [GIW-1:0] grp_idx
);

  logic       close;
  logic       hit_a;
  logic       hit_b;
  logic       hit_w;
  logic       at_start;
  viol_code_e code;

  assign close = in_vld & (stop_after | br_taken);

  grp_wset #(.NREG(NREG), .RW(RW)) u_wset (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_vld),
    .clr    (close),
    .wr_vld (dst_vld),
    .wr_idx (dst),
    .rd_a   (src_a),
    .rd_b   (src_b),
    .rd_w   (dst),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .hit_w  (hit_w)
  );

  grp_seq #(.GIW(GIW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (in_vld),
    .close    (close),
    .at_start (at_start),
    .idx      (grp_idx)
  );

  grp_classify u_cls (
    .in_vld    (in_vld),
    .src_a_vld (src_a_vld),
    .src_b_vld (src_b_vld),
    .dst_vld   (dst_vld),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .hit_w     (hit_w),
    .code      (code)
  );

  assign viol_code = code;
  assign viol      = (code != VC_NONE);
  assign grp_start = in_vld & at_start;

endmodule

// File: rtl/grp_hazard_sva.sv
module grp_hazard_sva #(
  parameter int RW  = 7,
  parameter int GIW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [RW-1:0]  src_a,
  input logic           src_a_vld,
  input logic [RW-1:0]  src_b,
  input logic           src_b_vld,
  input logic [RW-1:0]  dst,
  input logic           dst_vld,
  input logic           stop_after,
  input logic           br_taken,
  input logic           viol,
  input logic [1:0]     viol_code,
  input logic           grp_start,
  input logic [GIW-1:0] grp_idx
);

  // R1: read of the register the previous open-group instruction wrote
  a_r1_raw_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && $past(in_vld) && $past(dst_vld) && ($past(dst) != '0) &&
     !$past(stop_after || br_taken) && src_a_vld && (src_a == $past(dst)))
    |-> viol_code[0]);

  // R2: rewrite of the register the previous open-group instruction wrote
  a_r2_waw_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && $past(in_vld) && $past(dst_vld) && ($past(dst) != '0) &&
     !$past(stop_after || br_taken) && dst_vld && (dst == $past(dst)))
    |-> viol_code[1]);

  // R3, R4: the first instruction after a close sees an empty record
  a_r3_fresh_group: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && $past(in_vld && (stop_after || br_taken)))
    |-> (grp_start && !viol));

  // R6: register 0 reads are never flagged
  a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (!src_a_vld || src_a == '0) && (!src_b_vld || src_b == '0))
    |-> !viol_code[0]);

  // R7: nothing is reported without an instruction
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> (!viol && viol_code == 2'b00 && !grp_start));

  // R8: group number steps once per close, otherwise holds
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && (stop_after || br_taken))
    |-> (grp_idx == GIW'($past(grp_idx) + GIW'(1))));

  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld && (stop_after || br_taken)) |-> $stable(grp_idx));

endmodule

bind grp_hazard_chk grp_hazard_sva #(.RW(RW), .GIW(GIW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .src_a      (src_a),
  .src_a_vld  (src_a_vld),
  .src_b      (src_b),
  .src_b_vld  (src_b_vld),
  .dst        (dst),
  .dst_vld    (dst_vld),
  .stop_after (stop_after),
  .br_taken   (br_taken),
  .viol       (viol),
  .viol_code  (viol_code),
  .grp_start  (grp_start),
  .grp_idx    (grp_idx)
);

// File: tb/sim_grp_hazard_chk.sv
`timescale 1ns/1ps
module sim_grp_hazard_chk;

  localparam int RW  = 7;
  localparam int GIW = 8;

  logic           clk;
  logic           rst_n;
  logic           in_vld;
  logic [RW-1:0]  src_a;
  logic           src_a_vld;
  logic [RW-1:0]  src_b;
  logic           src_b_vld;
  logic [RW-1:0]  dst;
  logic           dst_vld;
  logic           stop_after;
  logic           br_taken;
  logic           viol;
  logic [1:0]     viol_code;
  logic           grp_start;
  logic [GIW-1:0] grp_idx;

  int             total;
  int             bad;
  bit             finished;
  logic [GIW-1:0] exp_idx;
  bit             fresh;

  grp_hazard_chk #(.NREG(128), .RW(RW), .GIW(GIW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .src_a(src_a), .src_a_vld(src_a_vld),
    .src_b(src_b), .src_b_vld(src_b_vld),
    .dst(dst), .dst_vld(dst_vld),
    .stop_after(stop_after), .br_taken(br_taken),
    .viol(viol), .viol_code(viol_code),
    .grp_start(grp_start), .grp_idx(grp_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sends one instruction; checks {viol, code, start, idx} before the recording edge.
  task automatic issue(input int sa, input bit sav, input int sb, input bit sbv,
                       input int d, input bit dv, input bit st, input bit br,
                       input logic [1:0] ec, input string tag);
    @(negedge clk);
    in_vld = 1'b1;
    src_a = RW'(sa); src_a_vld = sav;
    src_b = RW'(sb); src_b_vld = sbv;
    dst = RW'(d);    dst_vld = dv;
    stop_after = st; br_taken = br;
    #2;
    chk(tag, {20'd0, viol, viol_code, grp_start, grp_idx},
             {20'd0, (ec != 2'b00), ec, fresh, exp_idx});
    fresh = st | br;
    if (st | br) exp_idx = exp_idx + GIW'(1);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_vld = 1'b0;
    #2;
    chk(tag, {28'd0, viol, viol_code, grp_start}, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_vld = 1'b0;
    #2;
    chk("R9 reset outputs", {20'd0, viol, viol_code, grp_start, grp_idx}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_idx = '0;
    fresh = 1'b1;
  endtask

  task automatic t_raw();
    issue(1, 0, 2, 0, 5, 1, 0, 0, 2'b00, "R1 first write");
    issue(5, 1, 0, 0, 6, 1, 0, 0, 2'b01, "R1 read src_a after write");
    issue(0, 0, 6, 1, 8, 1, 0, 0, 2'b01, "R1 read src_b after write");
    issue(7, 1, 0, 0, 7, 1, 1, 0, 2'b00, "R1 own destination not a hazard");
  endtask

  task automatic t_waw();
    issue(0, 0, 0, 0, 9, 1, 0, 0, 2'b00, "R2 first write");
    issue(0, 0, 0, 0, 9, 1, 0, 0, 2'b10, "R2 rewrite");
    issue(9, 1, 0, 0, 9, 1, 1, 0, 2'b11, "R2 both hazards");
  endtask

  task automatic t_stop();
    issue(0, 0, 0, 0, 3, 1, 0, 0, 2'b00, "R3 write in group");
    issue(0, 0, 0, 0, 4, 1, 1, 0, 2'b00, "R3 closing write with stop");
    issue(3, 1, 4, 1, 4, 1, 0, 0, 2'b00, "R3 new group sees empty record");
    issue(0, 0, 4, 1, 0, 0, 1, 0, 2'b01, "R3 record rebuilt in new group");
  endtask

  task automatic t_branch();
    issue(0, 0, 0, 0, 12, 1, 0, 1, 2'b00, "R4 write with taken branch");
    issue(12, 1, 0, 0, 12, 1, 0, 0, 2'b00, "R4 branch closed group");
    issue(0, 0, 0, 0, 12, 1, 0, 0, 2'b10, "R4 same group continues");
    issue(0, 0, 0, 0, 0, 0, 1, 0, 2'b00, "R4 close");
  endtask

  task automatic t_long();
    issue(0, 0, 0, 0, 20, 1, 0, 0, 2'b00, "R5 early write");
    for (int k = 21; k < 51; k++) issue(k - 1, 0, 0, 0, k, 1, 0, 0, 2'b00, "R5 filler");
    idle("R7 idle no report");
    idle("R7 idle no report");
    issue(20, 1, 0, 0, 0, 0, 0, 0, 2'b01, "R5 late read after idles");
    issue(0, 0, 50, 1, 0, 0, 1, 0, 2'b01, "R7 record kept through idles");
  endtask

  task automatic t_zero();
    issue(0, 0, 0, 0, 0, 1, 0, 0, 2'b00, "R6 write r0");
    issue(0, 1, 0, 1, 0, 1, 0, 0, 2'b00, "R6 read and write r0");
    issue(0, 1, 0, 0, 0, 1, 1, 0, 2'b00, "R6 r0 never flagged");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 260; k++) issue(0, 0, 0, 0, 0, 0, 1, 0, 2'b00, "R8 group number steps");
    issue(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R8 wrapped number");
  endtask

  task automatic t_reset_mid();
    issue(0, 0, 0, 0, 11, 1, 0, 0, 2'b00, "R9 write before reset");
    do_reset();
    issue(11, 1, 0, 0, 11, 1, 0, 0, 2'b00, "R9 record cleared by reset");
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    exp_idx = '0; fresh = 1'b1;
    rst_n = 1'b0; in_vld = 1'b0;
    src_a = '0; src_a_vld = 1'b0; src_b = '0; src_b_vld = 1'b0;
    dst = '0; dst_vld = 1'b0; stop_after = 1'b0; br_taken = 1'b0;
    #1;
    chk("R9 outputs during reset", {20'd0, viol, viol_code, grp_start, grp_idx}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R7 idle after reset");
    t_raw();
    t_waw();
    t_stop();
    t_branch();
    t_long();
    t_zero();
    t_wrap();
    t_reset_mid();
    idle("R7 final idle");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule